// File: doc/BRIEF.md
# Dual-Read Integer Register File with Same-Cycle Write Forwarding

This block is the integer register file of a pipelined RISC-V style core. It keeps thirty-one 32-bit general-purpose registers, numbered 1 to 31. Register 0 has no storage and always reads as zero. Two read ports decode operand addresses and return data without a clock. One write port commits a result on the rising clock edge.

Each read port compares its address with the write address in the current cycle. When a write to the same nonzero register is pending, the port returns the incoming write data instead of the old stored word. A decode stage can therefore consume a result in the same cycle that the writeback stage retires it, with no stall. The register contents have no reset. Software, or the bench, must write a register before its value means anything.

Top module: `regfile_2r1w`

## Requirements
- R1: A read port whose address is 0 returns 0x00000000 in the same cycle, whatever the write enable, write address and write data are.
- R2: When the write enable is 1, the write address is nonzero and it equals the port A read address, `rd_data_a` equals `wr_data` combinationally in that cycle, before the clock edge.
- R3: When the write enable is 1, the write address is nonzero and it equals the port B read address, `rd_data_b` equals `wr_data` combinationally in that cycle, before the clock edge.
- R4: When both read addresses equal the nonzero write address and the write enable is 1, both ports show the write data at the same time.
- R5: A port with a nonzero address that does not match an active write returns the word stored in that register.
- R6: On a rising edge with the write enable at 1 and a nonzero write address, the addressed register takes `wr_data`. From the next cycle it is readable on either port.
- R7: A rising edge with the write enable at 0 changes no stored register, whatever the write address and write data are.
- R8: A write to address 0 changes no stored register, and it is never forwarded to a port that reads address 0.
- R9: Forwarding applies only in the cycle of the matching write. With the write enable at 0 and a matching address, a port returns the stored word.
- R10: The two ports are independent. Distinct addresses on A and B return their own registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| wr_en | input | 1 | Write enable, active high |
| wr_addr | input | 5 | Destination register number |
| wr_data | input | 32 | Data to write |
| rd_addr_a | input | 5 | Port A register number |
| rd_addr_b | input | 5 | Port B register number |
| rd_data_a | output | 32 | Port A read data |
| rd_data_b | output | 32 | Port B read data |

## Verification
The read results, the zero rule and the forwarding are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples the outputs one nanosecond later, before the next rising edge. A committed write is due one rising edge after it is presented. It is checked in a later cycle, with the write enable low or aimed at another register, so a stored value is never confused with a forwarded one. Blocked writes (enable low, or address 0) are checked by reading back every register through both ports after the attempt.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_ADDR_W = 5;
    localparam int RF_DATA_W = 32;

    // Source chosen by a read port, in priority order
    typedef enum logic [1:0] {
        RD_SRC_ZERO  = 2'd0,
        RD_SRC_FWD   = 2'd1,
        RD_SRC_STORE = 2'd2
    } rd_src_e;

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int ADDR_W   = rf_pkg::RF_ADDR_W,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    output logic [NUM_REGS-1:1]  wr_lines
);

    // One-hot decode gated by the enable; entry 0 has no line at all
    for (genvar k = 1; k < NUM_REGS; k++) begin : g_line
        assign wr_lines[k] = wr_en && (wr_addr == ADDR_W'(k));
    end

    always_comb begin
        // R7
        wr_gate_chk: assert (wr_en || (wr_lines == '0));
        // R6
        wr_onehot_chk: assert ($onehot0(wr_lines));
        // R8
        wr_zero_chk: assert ((wr_addr != '0) || (wr_lines == '0));
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int ADDR_W   = rf_pkg::RF_ADDR_W,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                              clk,
    input  logic [NUM_REGS-1:1]               wr_lines,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   arr_all
);

    typedef struct packed {
        logic [NUM_REGS-1:1][DATA_W-1:0] regs;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 1; k < NUM_REGS; k++) begin
            if (wr_lines[k]) begin
                st_d.regs[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign arr_all[0] = '0;
    for (genvar k = 1; k < NUM_REGS; k++) begin : g_out
        assign arr_all[k] = st_q.regs[k];
    end

    // Assertion support: becomes 1 after the first edge
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
    end

    for (genvar k = 1; k < NUM_REGS; k++) begin : g_chk
        // R6
        commit_chk: assert property (@(posedge clk) disable iff (!armed_q)
            wr_lines[k] |=> (st_q.regs[k] == $past(wr_data)));
        // R7
        hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
            !wr_lines[k] |=> $stable(st_q.regs[k]));
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int ADDR_W   = rf_pkg::RF_ADDR_W,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                              clk,
    input  logic [ADDR_W-1:0]                 rd_addr,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   arr_all,
    output logic [DATA_W-1:0]                 rd_data
);
    import rf_pkg::*;

    rd_src_e            src;
    logic               fwd_hit;
    logic [DATA_W-1:0]  stored_word;

    assign stored_word = arr_all[rd_addr];
    assign fwd_hit     = wr_en && (wr_addr != '0) && (wr_addr == rd_addr);

    // Priority: zero address, then forward match, then stored word
    always_comb begin
        if (rd_addr == '0) begin
            src = RD_SRC_ZERO;
        end else if (fwd_hit) begin
            src = RD_SRC_FWD;
        end else begin
            src = RD_SRC_STORE;
        end
    end

    always_comb begin
        unique case (src)
            RD_SRC_ZERO:  rd_data = '0;
            RD_SRC_FWD:   rd_data = wr_data;
            RD_SRC_STORE: rd_data = stored_word;
            default:      rd_data = '0;
        endcase
    end

    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
    end

    // R1
    zero_read_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (rd_addr == '0) |-> (rd_data == '0));
    // R2
    fwd_read_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (wr_en && (wr_addr == rd_addr) && (rd_addr != '0)) |-> (rd_data == wr_data));
    // R5
    store_read_chk: assert property (@(posedge clk) disable iff (!armed_q)
        ((rd_addr != '0) && !(wr_en && (wr_addr == rd_addr))) |-> (rd_data == arr_all[rd_addr]));

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    parameter int DATA_W = rf_pkg::RF_DATA_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int NUM_RD   = 2;

    logic [NUM_REGS-1:1]             wr_lines;
    logic [NUM_REGS-1:0][DATA_W-1:0] arr_all;
    logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;
    assign rd_data_a    = rd_data_v[0];
    assign rd_data_b    = rd_data_v[1];

    rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_lines (wr_lines)
    );

    rf_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .wr_lines (wr_lines),
        .wr_data  (wr_data),
        .arr_all  (arr_all)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
            .clk     (clk),
            .rd_addr (rd_addr_v[p]),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .arr_all (arr_all),
            .rd_data (rd_data_v[p])
        );
    end

    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
    end

    // R4
    dual_fwd_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (wr_en && (wr_addr != '0) && (rd_addr_a == wr_addr) && (rd_addr_b == wr_addr))
        |-> ((rd_data_a == wr_data) && (rd_data_b == wr_data)));
    // R10
    same_addr_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

// File: tb/test_regfile_2r1w.sv
module test_regfile_2r1w;

    logic        clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    regfile_2r1w i_regfile_2r1w (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R2: forward on A, B reads x0
        '{"R2 ", 1'b1, 5'd5,  32'hDEADBEEF, 5'd5,  5'd0,  32'hDEADBEEF, 32'h0},
        // R3: forward on B, A reads committed x5
        '{"R3 ", 1'b1, 5'd2,  32'h00001111, 5'd5,  5'd2,  32'hDEADBEEF, 32'h00001111},
        // R9: enable low, matching address, stored words
        '{"R9 ", 1'b0, 5'd5,  32'hFFFFFFFF, 5'd5,  5'd2,  32'hDEADBEEF, 32'h00001111},
        // R1: write to x0 while both ports read x0
        '{"R1 ", 1'b1, 5'd0,  32'hCAFEF00D, 5'd0,  5'd0,  32'h0,        32'h0},
        // R4: both ports on the written register
        '{"R4 ", 1'b1, 5'd31, 32'h80000001, 5'd31, 5'd31, 32'h80000001, 32'h80000001},
        // R10: distinct registers on the two ports
        '{"R10", 1'b0, 5'd5,  32'h0,        5'd31, 5'd5,  32'h80000001, 32'hDEADBEEF},
        // R5: no match, stored words on both
        '{"R5 ", 1'b1, 5'd1,  32'h12345678, 5'd2,  5'd31, 32'h00001111, 32'h80000001},
        // R2: forwarding a zero word
        '{"R2 ", 1'b1, 5'd5,  32'h0,        5'd1,  5'd5,  32'h12345678, 32'h0},
        // R6: committed values visible next cycle
        '{"R6 ", 1'b0, 5'd0,  32'h0,        5'd5,  5'd1,  32'h0,        32'h12345678}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                         input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        #1;
    endtask

    function automatic logic [31:0] pat(input int k);
        return (32'(k) * 32'h01010101) ^ 32'hA55A3CC3;
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset-state read of x0 before any write
        drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
        check("R1", "x0 port A idle", rd_data_a, 32'h0);
        check("R1", "x0 port B idle", rd_data_b, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].ra, VECS[i].rb);
            check(string'(VECS[i].tag), $sformatf("row %0d port A", i), rd_data_a, VECS[i].ea);
            check(string'(VECS[i].tag), $sformatf("row %0d port B", i), rd_data_b, VECS[i].eb);
        end

        // R6: fill every register, forwarding seen on A during each write
        for (int k = 1; k < 32; k++) begin
            drive(1'b1, 5'(k), pat(k), 5'(k), 5'd0);
            check("R2", "fill forward A", rd_data_a, pat(k));
        end

        // R7: enable low to every register
        for (int k = 1; k < 32; k++) begin
            drive(1'b0, 5'(k), ~pat(k), 5'd0, 5'(k));
            check("R9", "no forward with enable low", rd_data_b, pat(k));
        end
        // R8: enabled writes to address 0
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 5'd0, 32'hFFFF0000 | 32'(k), 5'd0, 5'd0);
            check("R8", "x0 write not forwarded A", rd_data_a, 32'h0);
            check("R8", "x0 write not forwarded B", rd_data_b, 32'h0);
        end
        // R7 R8: read back all registers on both ports
        for (int k = 1; k < 32; k++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(k), 5'(32 - k));
            check("R7", "hold port A", rd_data_a, pat(k));
            check("R7", "hold port B", rd_data_b, pat(32 - k));
        end

        // R3: forward on B while A reads another stored register
        drive(1'b1, 5'd9, 32'h0BADF00D, 5'd10, 5'd9);
        check("R3", "forward B", rd_data_b, 32'h0BADF00D);
        check("R10", "A independent", rd_data_a, pat(10));
        drive(1'b0, 5'd9, 32'h0, 5'd9, 5'd9);
        check("R6", "commit x9 A", rd_data_a, 32'h0BADF00D);
        check("R6", "commit x9 B", rd_data_b, 32'h0BADF00D);

        // R4: back-to-back writes to the same register, both ports forwarding
        drive(1'b1, 5'd17, 32'h11112222, 5'd17, 5'd17);
        check("R4", "dual forward first A", rd_data_a, 32'h11112222);
        check("R4", "dual forward first B", rd_data_b, 32'h11112222);
        drive(1'b1, 5'd17, 32'h33334444, 5'd17, 5'd17);
        check("R4", "dual forward second A", rd_data_a, 32'h33334444);
        check("R4", "dual forward second B", rd_data_b, 32'h33334444);
        drive(1'b0, 5'd17, 32'h0, 5'd17, 5'd0);
        check("R6", "last write wins", rd_data_a, 32'h33334444);
        check("R1", "x0 alongside", rd_data_b, 32'h0);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule